// File: doc/BRIEF.md
# Coincident-Selection RAM Array

This block is a small synchronous random-access memory whose bit cells sit in a square grid instead of one tall column of words. The flat word address is cut in two. The high-order part picks one grid row through a row decoder. The low-order part picks one word-wide group of adjacent columns inside that row through a second, column decoder. A cell takes part in an access only where its row select and its column select are both active. Compared with one full-address decoder, this keeps both decoders short.

Three active-low strobes control access. Chip select must be low for anything to happen. The write strobe commits data on a rising clock edge. Output enable lets a read reach the data output. Read data is registered. A deselected or disabled output reads as zero, which stands in for a released bus. The grid height, the words per row and the word width are parameters. The default is 8 rows by 8 columns, with two 4-bit words per row, for 16 words in total.

Top module: `csram_grid`

## Requirements
- R1: While `rst` is high, every cell is cleared and `rd_data` is zero. After reset, every address reads back as zero.
- R2: On a rising edge with `cs_n` = 0 and `we_n` = 0, the word at `addr` takes the value of `wr_data`.
- R3: On a rising edge with `cs_n` = 0, `oe_n` = 0 and `we_n` = 1, `rd_data` takes the word stored at `addr` and holds it until the next edge.
- R4: While `cs_n` = 1, no cell changes whatever `we_n` does. The edge after such a cycle leaves `rd_data` at zero.
- R5: An edge with `cs_n` = 0, `we_n` = 1 and `oe_n` = 1 leaves `rd_data` at zero.
- R6: A write changes only the addressed word. The other words of the same row and all other rows keep their contents.
- R7: The row index is `addr[ADDR_W-1:COL_W]` and the word-in-row index is `addr[COL_W-1:0]`. Word w of a row occupies columns w*WORD_W to w*WORD_W+WORD_W-1. With chip select low, exactly one row select and exactly one column select are active. Every address has storage of its own.
- R8: An edge on which a write is committed leaves `rd_data` at zero for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address: row field high, column field low |
| wr_data | input | WORD_W | Data to store on a write |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| rd_data | output | WORD_W | Registered read data, zero when not reading |

## Verification
A write lands in the grid on the same rising edge that samples `cs_n`/`we_n` low. It becomes visible only through a later read. A read, a disabled read or a write shows its result on `rd_data` right after the edge that samples it, and that value holds for one full cycle. The bench drives every stimulus on the falling edge. It samples `rd_data` on the next falling edge, half a cycle after the edge that loaded the register. Back-to-back sequences sample each result at the falling edge that follows its own sampling edge.

// File: rtl/csram_pkg.sv
package csram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } ram_op_e;

    typedef struct packed {
        logic sel;
        logic out_en;
        logic wr_en;
    } ram_ctrl_t;

    function automatic ram_ctrl_t ctrl_from_pins(input logic cs_n,
                                                 input logic oe_n,
                                                 input logic we_n);
        ram_ctrl_t c;
        c.sel    = ~cs_n;
        c.out_en = ~oe_n;
        c.wr_en  = ~we_n;
        return c;
    endfunction

    function automatic ram_op_e op_from_ctrl(input ram_ctrl_t c);
        if (!c.sel)        return OP_IDLE;
        else if (c.wr_en)  return OP_WRITE;
        else if (c.out_en) return OP_READ;
        else               return OP_IDLE;
    endfunction

endpackage

// File: rtl/csram_dec.sv
module csram_dec #(
    parameter int N_OUT = 8,
    parameter int IN_W  = 3
) (
    input  logic             en,
    input  logic [IN_W-1:0]  idx,
    output logic [N_OUT-1:0] sel
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_line
        assign sel[i] = en && (idx == IN_W'(i));
    end
endmodule

// File: rtl/csram_cells.sv
module csram_cells #(
    parameter int ROWS   = 8,
    parameter int WPR    = 2,
    parameter int WORD_W = 4,
    localparam int COLS  = WPR * WORD_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ROWS-1:0]            row_sel,
    input  logic [WPR-1:0]             col_sel,
    input  logic                       wr_en,
    input  logic [WORD_W-1:0]          wr_data,
    output logic [ROWS-1:0][COLS-1:0]  cell_out
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int W = c / WORD_W;
            localparam int B = c % WORD_W;
            logic q;
            logic bit_sel;
            assign bit_sel = row_sel[r] & col_sel[W];
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (wr_en && bit_sel)
                    q <= wr_data[B];
            end
            assign cell_out[r][c] = q & bit_sel;
        end
    end
endmodule

// File: rtl/csram_colmux.sv
module csram_colmux #(
    parameter int ROWS   = 8,
    parameter int WPR    = 2,
    parameter int WORD_W = 4,
    localparam int COLS  = WPR * WORD_W
) (
    input  logic [ROWS-1:0][COLS-1:0] cell_out,
    output logic [WORD_W-1:0]         word
);
    always_comb begin
        word = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int w = 0; w < WPR; w++) begin
                for (int b = 0; b < WORD_W; b++) begin
                    word[b] = word[b] | cell_out[r][w*WORD_W + b];
                end
            end
        end
    end
endmodule

// File: rtl/csram_grid.sv
module csram_grid #(
    parameter int ROWS          = 8,
    parameter int WORDS_PER_ROW = 2,
    parameter int WORD_W        = 4,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(WORDS_PER_ROW),
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int COLS   = WORDS_PER_ROW * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [WORD_W-1:0] rd_data
);
    import csram_pkg::*;

    ram_ctrl_t                  ctrl;
    ram_op_e                    op;
    logic [ROWS-1:0]            row_sel;
    logic [WORDS_PER_ROW-1:0]   col_sel;
    logic [ROWS-1:0][COLS-1:0]  cell_out;
    logic [WORD_W-1:0]          mux_word;
    logic [WORD_W-1:0]          rd_q;

    assign ctrl = ctrl_from_pins(cs_n, oe_n, we_n);
    assign op   = op_from_ctrl(ctrl);

    csram_dec #(.N_OUT(ROWS), .IN_W(ROW_W)) row_dec_i (
        .en  (ctrl.sel),
        .idx (addr[ADDR_W-1:COL_W]),
        .sel (row_sel)
    );

    csram_dec #(.N_OUT(WORDS_PER_ROW), .IN_W(COL_W)) col_dec_i (
        .en  (ctrl.sel),
        .idx (addr[COL_W-1:0]),
        .sel (col_sel)
    );

    csram_cells #(.ROWS(ROWS), .WPR(WORDS_PER_ROW), .WORD_W(WORD_W)) cells_i (
        .clk      (clk),
        .rst      (rst),
        .row_sel  (row_sel),
        .col_sel  (col_sel),
        .wr_en    (op == OP_WRITE),
        .wr_data  (wr_data),
        .cell_out (cell_out)
    );

    csram_colmux #(.ROWS(ROWS), .WPR(WORDS_PER_ROW), .WORD_W(WORD_W)) mux_i (
        .cell_out (cell_out),
        .word     (mux_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (op == OP_READ)
            rd_q <= mux_word;
        else
            rd_q <= '0;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/csram_grid_chk.sv
module csram_grid_chk #(
    parameter int ROWS   = 8,
    parameter int WPR    = 2,
    parameter int WORD_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [WORD_W-1:0] rd_data,
    input logic [ROWS-1:0]   row_sel,
    input logic [WPR-1:0]    col_sel
);
    // R1
    reset_clears_out_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    // R4
    deselect_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (rd_data == '0));

    // R5
    oe_off_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && oe_n) |=> (rd_data == '0));

    // R8
    write_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n) |=> (rd_data == '0));

    // R7
    one_row_one_col_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> ($onehot(row_sel) && $onehot(col_sel)));

    // R4
    no_select_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (row_sel == '0 && col_sel == '0));
endmodule

bind csram_grid csram_grid_chk #(
    .ROWS(ROWS), .WPR(WORDS_PER_ROW), .WORD_W(WORD_W)
) chk_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .rd_data(rd_data), .row_sel(row_sel), .col_sel(col_sel)
);

// File: tb/csram_grid_tb.sv
module csram_grid_tb_top;
    localparam int ROWS = 8;
    localparam int WPR  = 2;
    localparam int WW   = 4;
    localparam int AW   = 4;
    localparam int NW   = ROWS * WPR;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic          cs_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [WW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [WW-1:0] model [NW];
    logic [WW-1:0] got;

    always #5 clk = ~clk;

    csram_grid #(.ROWS(ROWS), .WORDS_PER_ROW(WPR), .WORD_W(WW)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [WW-1:0] act,
                         input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [WW-1:0] d);
        @(negedge clk);
        addr = AW'(a); wr_data = d; cs_n = 0; we_n = 0; oe_n = 1;
        @(negedge clk);
        cs_n = 1; we_n = 1;
        model[a] = d;
    endtask

    task automatic do_read(input int a, output logic [WW-1:0] d);
        @(negedge clk);
        addr = AW'(a); cs_n = 0; we_n = 1; oe_n = 0;
        @(negedge clk);
        d = rd_data;
        cs_n = 1; oe_n = 1;
    endtask

    task automatic verify_all(input string req);
        for (int a = 0; a < NW; a++) begin
            do_read(a, got);
            check(req, got, model[a]);
        end
    endtask

    initial begin
        for (int a = 0; a < NW; a++) model[a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 out after reset", rd_data, '0);
        verify_all("R1 cleared grid");

        // R2 R7: distinct word per address, whole range
        for (int a = 0; a < NW; a++) do_write(a, WW'(a * 5 + 3));
        verify_all("R2/R7 pattern A");
        for (int a = NW - 1; a >= 0; a--) do_write(a, ~WW'(a * 5 + 3));
        verify_all("R2/R7 pattern B");

        // R6: one word per row rewritten, neighbours must stay
        for (int r = 0; r < ROWS; r++) begin
            do_write(r * WPR + (r % WPR), WW'(r + 9));
            for (int w = 0; w < WPR; w++) begin
                do_read(r * WPR + w, got);
                check("R6 row neighbour", got, model[r * WPR + w]);
            end
        end
        verify_all("R6 whole grid");

        // R4: write strobe without chip select
        @(negedge clk);
        addr = AW'(5); wr_data = ~model[5]; cs_n = 1; we_n = 0; oe_n = 0;
        @(negedge clk);
        check("R4 out while deselected", rd_data, '0);
        we_n = 1; oe_n = 1;
        do_read(5, got);
        check("R4 no write deselected", got, model[5]);

        // R3 R5: read then read with output disabled, back to back
        @(negedge clk);
        addr = AW'(9); cs_n = 0; we_n = 1; oe_n = 0;
        @(negedge clk);
        check("R3 read data", rd_data, model[9]);
        oe_n = 1;
        @(negedge clk);
        check("R5 output disabled", rd_data, '0);
        cs_n = 1;

        // R3 R8: read then write, back to back
        @(negedge clk);
        addr = AW'(12); cs_n = 0; we_n = 1; oe_n = 0;
        @(negedge clk);
        check("R3 read before write", rd_data, model[12]);
        addr = AW'(13); wr_data = 4'h6; we_n = 0;
        @(negedge clk);
        check("R8 out after write", rd_data, '0);
        model[13] = 4'h6;
        cs_n = 1; we_n = 1; oe_n = 1;
        verify_all("R2/R6 after mixed");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule